// File: doc/BRIEF.md
# Floppy Adapter Host Register File

This block is the processor-facing register interface of a four-drive floppy adapter. It decodes an eight-port I/O window at a base address and answers the same way at a second window 16 ports higher. Through this window the host reads a subsystem status byte, reads a result type, and reads a result byte. The host also loads a two-byte parameter-block pointer and can issue a software reset.

The high-byte write of the pointer sends a one-clock start pulse to a separate execution engine. That engine reports each drive's ready state, whether it is busy, and a completion strobe with an error flag and an error code. The block keeps an interrupt flip-flop, the latest error byte, the registered drive-ready bits and a ready-changed flag. The interrupt flip-flop drives an active-high interrupt line.

Port offsets within the window: 0 status (read), 1 result type (read) / pointer low (write), 2 pointer high and start (write), 3 result byte (read), 7 software reset (write). Offsets 4 to 6 are unused.

Top module: `disk_host_regs`

## Requirements
- R1: An access hits only when the port address lies within BASE_PORT..BASE_PORT+7 or BASE_PORT+16..BASE_PORT+23, and both windows behave identically. A read that misses, a read of offsets 2, 4, 5, 6 or 7, and any cycle without a read all return 0x00. Writes to offsets 3 to 6, and writes that miss, change no state.
- R2: The status byte reads as follows. Bit 0 is drive 0 ready and bit 1 is drive 1 ready. Bit 2 is the interrupt flip-flop. Bits 3 and 4 are the presence indicators and always read 1. Bit 5 is drive 2 ready, bit 6 is drive 3 ready, and bit 7 reads 0.
- R3: A read of offset 1 returns the result type in bits 1:0 with bits 7:2 zero. Code 2'b00 means error and 2'b10 means ready status. The same read clears the interrupt flip-flop, unless a completion arrives in that cycle.
- R4: A completion strobe sets the interrupt flip-flop. With the error flag set, it also sets the result type to 2'b00 and captures the 8-bit error code. Without it, it sets the result type to 2'b10. A completion wins over a result-type read in the same cycle.
- R5: A read of offset 3 returns the error byte when the result type is 2'b00. Otherwise it returns the ready byte if the ready-changed flag is set, and 0x00 if the flag is clear.
- R6: The ready byte has bits 3:0 zero, bit 4 drive 2, bit 5 drive 3, bit 6 drive 0 and bit 7 drive 1. The drive-ready bits follow the ready inputs one clock later. Any difference between the inputs and the held bits sets the ready-changed flag.
- R7: A write to offset 1 makes the pointer {0x00, data}. A write to offset 2 ORs the data into the pointer's high byte and leaves its low byte unchanged.
- R8: A write to offset 2 while busy is low raises the start output for exactly the next clock cycle. A write while busy is high gives no start pulse.
- R9: A write to offset 7 clears the interrupt flip-flop and the ready-changed flag, sets the result type to 2'b10, and reloads the drive-ready bits from the ready inputs.
- R10: The interrupt output equals the interrupt flip-flop. After reset it is low, the result type is 2'b10, and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | I/O port address |
| rd_i | input | 1 | Read strobe, side effects at the clock edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (8) | Write data |
| rdata_o | output | DATA_W (8) | Read data, valid while rd_i is high |
| drv_rdy_i | input | NUM_DRV (4) | Per-drive ready from the engine |
| busy_i | input | 1 | Engine busy, suppresses start |
| done_i | input | 1 | Operation-complete strobe |
| done_err_i | input | 1 | Completion carries an error |
| err_code_i | input | DATA_W (8) | Error byte captured on an error completion |
| start_o | output | 1 | One-clock start pulse to the engine |
| ptr_o | output | 2*DATA_W (16) | Parameter-block pointer |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The checker watches a set of rules on every cycle. Each start pulse must trace back to a non-busy high-byte write one cycle earlier. Reads that miss or hit an unused offset must return zero. The result-type and status bits must keep their fixed values. A completion must set the interrupt, and a result-type read or a software reset must clear it.

Some behaviours need a sequence of operations, so only the bench scenarios can show them. These are the OR-accumulation of the pointer, the choice of result-byte encoding from result type and ready-changed flag, and the full drive-bit placement over all sixteen ready patterns. A model-driven sweep of every port address covers the mirror window and the unused offsets.

// File: rtl/disk_host_pkg.sv
package disk_host_pkg;
  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [OFS_W-1:0] OFS_RTYPE  = 3'd1;  // read: result type, write: ptr low
  localparam logic [OFS_W-1:0] OFS_PTR_HI = 3'd2;
  localparam logic [OFS_W-1:0] OFS_RESULT = 3'd3;
  localparam logic [OFS_W-1:0] OFS_SRST   = 3'd7;

  localparam logic [1:0] RT_ERROR = 2'b00;
  localparam logic [1:0] RT_READY = 2'b10;

  function automatic logic [7:0] ready_byte(input logic [3:0] r);
    return {r[1], r[0], r[3], r[2], 4'b0000};
  endfunction

  function automatic logic [7:0] status_byte(input logic [3:0] r, input logic irq);
    return {1'b0, r[3], r[2], 1'b1, 1'b1, irq, r[1], r[0]};
  endfunction
endpackage

// File: rtl/disk_host_decode.sv
module disk_host_decode
  import disk_host_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_PORT = 'h78,
  parameter int MIRROR    = 16,
  parameter int NUM_WIN   = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [NUM_WIN-1:0] win_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(BASE_PORT + w * MIRROR);
    assign win_hit[w] = addr_i[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W];
  end

  assign hit_o = |win_hit;
  assign ofs_o = addr_i[OFS_W-1:0];
endmodule

// File: rtl/disk_host_ptr.sv
module disk_host_ptr #(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              start_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= hi_wr_i && !busy_i;
      if (lo_wr_i)
        ptr_q <= {{DATA_W{1'b0}}, wdata_i};
      else if (hi_wr_i)
        ptr_q[PTR_W-1:DATA_W] <= ptr_q[PTR_W-1:DATA_W] | wdata_i;
    end
  end

  assign ptr_o   = ptr_q;
  assign start_o = start_q;
endmodule

// File: rtl/disk_host_result.sv
module disk_host_result
  import disk_host_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_DRV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               rtype_rd_i,
  input  logic               done_i,
  input  logic               done_err_i,
  input  logic [DATA_W-1:0]  err_code_i,
  input  logic [NUM_DRV-1:0] drv_rdy_i,
  output logic               irq_o,
  output logic [1:0]         rtype_o,
  output logic [DATA_W-1:0]  err_byte_o,
  output logic [NUM_DRV-1:0] rdy_o,
  output logic               rdy_chg_o
);
  logic               irq_q, chg_q;
  logic [1:0]         rtype_q;
  logic [DATA_W-1:0]  err_q;
  logic [NUM_DRV-1:0] rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      chg_q   <= 1'b0;
      rtype_q <= RT_READY;
      err_q   <= '0;
      rdy_q   <= '0;
    end else if (soft_rst_i) begin
      irq_q   <= 1'b0;
      chg_q   <= 1'b0;
      rtype_q <= RT_READY;
      rdy_q   <= drv_rdy_i;
    end else begin
      rdy_q <= drv_rdy_i;
      if (drv_rdy_i != rdy_q) chg_q <= 1'b1;
      if (done_i) begin
        irq_q <= 1'b1;
        if (done_err_i) begin
          rtype_q <= RT_ERROR;
          err_q   <= err_code_i;
        end else begin
          rtype_q <= RT_READY;
        end
      end else if (rtype_rd_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign irq_o      = irq_q;
  assign rtype_o    = rtype_q;
  assign err_byte_o = err_q;
  assign rdy_o      = rdy_q;
  assign rdy_chg_o  = chg_q;
endmodule

// File: rtl/disk_host_regs.sv
module disk_host_regs
  import disk_host_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_DRV   = 4,
  parameter int BASE_PORT = 'h78,
  parameter int MIRROR    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_DRV-1:0]    drv_rdy_i,
  input  logic                  busy_i,
  input  logic                  done_i,
  input  logic                  done_err_i,
  input  logic [DATA_W-1:0]     err_code_i,
  output logic                  start_o,
  output logic [2*DATA_W-1:0]   ptr_o,
  output logic                  irq_o
);
  logic               hit;
  logic [OFS_W-1:0]   ofs;
  logic               irq, chg;
  logic [1:0]         rtype;
  logic [DATA_W-1:0]  err_byte;
  logic [NUM_DRV-1:0] rdy;

  disk_host_decode #(
    .ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT), .MIRROR(MIRROR), .NUM_WIN(2)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .ofs_o(ofs)
  );

  disk_host_ptr #(.DATA_W(DATA_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lo_wr_i(wr_i && hit && ofs == OFS_RTYPE),
    .hi_wr_i(wr_i && hit && ofs == OFS_PTR_HI),
    .wdata_i(wdata_i), .busy_i(busy_i),
    .ptr_o(ptr_o), .start_o(start_o)
  );

  disk_host_result #(.DATA_W(DATA_W), .NUM_DRV(NUM_DRV)) u_res (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .soft_rst_i(wr_i && hit && ofs == OFS_SRST),
    .rtype_rd_i(rd_i && hit && ofs == OFS_RTYPE),
    .done_i(done_i), .done_err_i(done_err_i), .err_code_i(err_code_i),
    .drv_rdy_i(drv_rdy_i),
    .irq_o(irq), .rtype_o(rtype), .err_byte_o(err_byte),
    .rdy_o(rdy), .rdy_chg_o(chg)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit) begin
      unique case (ofs)
        OFS_STATUS: rdata_o = DATA_W'(status_byte(rdy, irq));
        OFS_RTYPE:  rdata_o = DATA_W'(rtype);
        OFS_RESULT: begin
          if (rtype == RT_ERROR) rdata_o = err_byte;
          else if (chg)          rdata_o = DATA_W'(ready_byte(rdy));
        end
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq;
endmodule

// File: rtl/disk_host_regs_chk.sv
module disk_host_regs_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BASE_PORT = 'h78,
  parameter int MIRROR    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              busy_i,
  input logic              done_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              start_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] W0 = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] W1 = ADDR_W'(BASE_PORT + MIRROR);

  logic in_win;
  logic [2:0] o;
  assign in_win = (addr_i[ADDR_W-1:3] == W0[ADDR_W-1:3]) || (addr_i[ADDR_W-1:3] == W1[ADDR_W-1:3]);
  assign o = addr_i[2:0];

  a_r1_idle_or_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || !in_win || o == 3'd2 || o > 3'd3) |-> rdata_o == '0);

  a_r2_status_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_win && o == 3'd0) |-> (rdata_o[7] == 1'b0 && rdata_o[4:3] == 2'b11));

  a_r3_rtype_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_win && o == 3'd1) |-> (rdata_o[7:2] == '0 && rdata_o[0] == 1'b0));

  a_r3_read_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_win && o == 3'd1 && !done_i) |=> !irq_o);

  a_r4_done_sets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !(wr_i && in_win && o == 3'd7)) |=> irq_o);

  a_r8_start_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_i && in_win && o == 3'd2 && !busy_i));

  a_r9_srst_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_win && o == 3'd7) |=> !irq_o);
endmodule

bind disk_host_regs disk_host_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_PORT(BASE_PORT), .MIRROR(MIRROR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .busy_i(busy_i), .done_i(done_i), .rdata_o(rdata_o), .start_o(start_o),
  .irq_o(irq_o)
);

// File: tb/tb_disk_host_regs.sv
`timescale 1ns/100ps
module tb_disk_host_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr = '0, wdata = '0, err_code = '0;
  logic rd = 1'b0, wr = 1'b0, busy = 1'b0, done = 1'b0, done_err = 1'b0;
  logic [3:0] drv_rdy = '0;
  logic [7:0] rdata;
  logic start, irq;
  logic [15:0] ptr;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic m_irq = 0, m_chg = 0;
  logic [1:0] m_rtype = 2'b10;
  logic [7:0] m_err = 0;
  logic [3:0] m_rdy = 0;
  logic [15:0] m_ptr = 0;

  always #2.5 clk = ~clk;

  disk_host_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .drv_rdy_i(drv_rdy), .busy_i(busy),
    .done_i(done), .done_err_i(done_err), .err_code_i(err_code),
    .start_o(start), .ptr_o(ptr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return 8'(m_rdy[0] + 2*m_rdy[1] + 4*m_irq + 8 + 16 + 32*m_rdy[2] + 64*m_rdy[3]);
  endfunction

  function automatic logic [7:0] exp_ready();
    return 8'(16*m_rdy[2] + 32*m_rdy[3] + 64*m_rdy[0] + 128*m_rdy[1]);
  endfunction

  function automatic logic in_window(input logic [7:0] a);
    return (a >= 8'h78 && a <= 8'h7f) || (a >= 8'h88 && a <= 8'h8f);
  endfunction

  // expected read value, then apply its side effect on the model
  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] v = 0;
    if (in_window(a)) begin
      case (a & 8'h07)
        0: v = exp_status();
        1: begin v = {6'd0, m_rtype}; m_irq = 0; end
        3: v = (m_rtype == 2'b00) ? m_err : (m_chg ? exp_ready() : 8'h00);
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic do_done(input logic e, input logic [7:0] c);
    @(negedge clk); done = 1; done_err = e; err_code = c;
    @(negedge clk); done = 0; done_err = 0;
    m_irq = 1;
    if (e) begin m_rtype = 2'b00; m_err = c; end else m_rtype = 2'b10;
  endtask

  task automatic set_rdy(input logic [3:0] r);
    @(negedge clk); drv_rdy = r;
    @(negedge clk);
    if (r != m_rdy) m_chg = 1;
    m_rdy = r;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    logic [7:0] d, e;
    e = exp_read(a);
    do_rd(a, d);
    chk(req, {8'h0, d}, {8'h0, e});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq after reset", {15'd0, irq}, 16'd0);
    chk("R10 ptr after reset", ptr, 16'h0000);
    rd_chk("R2 status after reset", 8'h78);
    rd_chk("R3 rtype after reset", 8'h79);
    rd_chk("R5 result with no ready change", 8'h7b);

    // R6 ready pattern sweep
    for (int r = 0; r < 16; r++) begin
      set_rdy(4'(r));
      rd_chk("R2 status drive bits", 8'h78);
      rd_chk("R6 ready byte", 8'h7b);
      rd_chk("R6 ready byte mirror", 8'h8b);
    end

    // R4 error completion, R3 read clears irq
    do_done(1'b1, 8'h88);
    chk("R4 irq on completion", {15'd0, irq}, 16'd1);
    rd_chk("R2 status irq bit", 8'h78);
    rd_chk("R5 error byte", 8'h7b);
    rd_chk("R3 rtype error read", 8'h79);
    chk("R3 irq cleared by read", {15'd0, irq}, 16'd0);
    rd_chk("R5 error byte persists", 8'h8b);

    // R1 full address sweep with irq pending, error result type
    do_done(1'b1, 8'h21);
    for (int a = 0; a < 256; a++) rd_chk("R1 address sweep", 8'(a));
    chk("R3 sweep cleared irq", {15'd0, irq}, {15'd0, m_irq});

    // ok completion, sweep again
    do_done(1'b0, 8'hff);
    for (int a = 0; a < 256; a++) rd_chk("R1 address sweep ok", 8'(a));

    // R7 / R8 pointer and start
    do_wr(8'h79, 8'h34); m_ptr = 16'h0034;
    chk("R8 no start on low write", {15'd0, start}, 16'd0);
    do_wr(8'h7a, 8'h12); m_ptr[15:8] |= 8'h12;
    chk("R8 start pulse", {15'd0, start}, 16'd1);
    chk("R7 ptr after hi write", ptr, m_ptr);
    @(negedge clk);
    chk("R8 start one clock wide", {15'd0, start}, 16'd0);
    do_wr(8'h8a, 8'h41); m_ptr[15:8] |= 8'h41;
    chk("R7 ptr OR via mirror", ptr, m_ptr);
    chk("R8 start via mirror", {15'd0, start}, 16'd1);
    busy = 1;
    do_wr(8'h7a, 8'h80); m_ptr[15:8] |= 8'h80;
    chk("R8 start suppressed by busy", {15'd0, start}, 16'd0);
    chk("R7 ptr OR while busy", ptr, m_ptr);
    busy = 0;
    do_wr(8'h89, 8'h01); m_ptr = 16'h0001;
    chk("R7 low write replaces", ptr, m_ptr);

    // R1 ignored writes
    do_done(1'b1, 8'h10);
    for (int a = 3; a < 7; a++) do_wr(8'h78 + 8'(a), 8'hff);
    do_wr(8'h80, 8'hff); do_wr(8'h77, 8'hff); do_wr(8'h6a, 8'hff);
    chk("R1 ignored writes keep ptr", ptr, m_ptr);
    chk("R1 ignored writes keep irq", {15'd0, irq}, 16'd1);
    rd_chk("R1 ignored writes keep status", 8'h78);
    rd_chk("R1 ignored writes keep error", 8'h7b);

    // R9 software reset
    drv_rdy = 4'b0101;
    do_wr(8'h8f, 8'h00);
    m_irq = 0; m_chg = 0; m_rtype = 2'b10; m_rdy = 4'b0101;
    chk("R9 irq cleared", {15'd0, irq}, 16'd0);
    rd_chk("R9 status reloaded", 8'h78);
    rd_chk("R9 rtype ready", 8'h79);
    rd_chk("R9 result zero, flag cleared", 8'h7b);
    set_rdy(4'b1100);
    rd_chk("R6 flag set after reset", 8'h7b);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule